// File: doc/BRIEF.md
# Vector Interface Command Decoder

The block sits at the head of a vector co-processor's input path. It takes 32-bit words from a DMA-style source through a valid/ready handshake and reads each command word as three fields. Bits 31:24 hold the opcode byte, and bit 31 of that byte is an interrupt flag. Bits 23:16 hold a count, and bits 15:0 hold an immediate. Some commands only set configuration registers: the write cycle pair, the double-buffer offset and base, the ITOP value, the add mode, the mark value, the write mask, and the row and column fill values. Other commands start the vector unit, announce a micro-memory upload or announce a forward to the graphics interface.

For each command the decoder works out how many payload words follow it and consumes exactly that many. Payload words never reach the command decoder. Upload and forward payloads are passed on as single-cycle data beats. Mask, row and column payloads are stored in the configuration registers.

When a command carries the interrupt flag, the interrupt request rises once the command has completed. Further commands are then held off until the request is acknowledged. The one exception is a MARK command, which still passes. The start address of the current buffer (`tops`) is derived from the base, the offset and a double-buffer flag, and is driven as an output.

Top module: `vcmd_decoder`

## Requirements
- R1: After reset all configuration outputs, `tops`, `cfg_dbf`, `irq`, `op_err`, `pay_valid`, `vu_start`, `mpg_req` and `gif_req` are 0, and `in_ready` is 1.
- R2: The opcode is taken from bits 30:24 of a command word, the count from bits 23:16 and the immediate from bits 15:0. Bit 31 does not change the opcode. One cycle after a command is accepted, the outputs update as follows: opcode 01h sets `cfg_cl` to imm[7:0] and `cfg_wl` to imm[15:8]. Opcode 03h sets `cfg_base` to imm[9:0]. Opcode 04h sets `cfg_itop` to imm[9:0]. Opcode 05h sets `cfg_mode` to imm[1:0]. Opcode 07h sets `cfg_mark` to imm[15:0]. Opcode 00h changes nothing.
- R3: Opcode 02h sets `cfg_ofs` to imm[9:0], clears `cfg_dbf`, and loads `cfg_base` with the `tops` value from before the command.
- R4: `tops` equals `cfg_base` when `cfg_dbf` is 0, and equals (`cfg_base` + `cfg_ofs`) mod 1024 when `cfg_dbf` is 1.
- R5: Opcode 14h gives a one-cycle `vu_start` with `vu_use_tpc`=0 and `vu_addr`=imm×8. Opcode 17h gives a one-cycle `vu_start` with `vu_use_tpc`=1. Each start inverts `cfg_dbf`. At most one of `vu_start`, `mpg_req` and `gif_req` is high in any cycle.
- R6: Opcode 20h consumes 1 payload word into `cfg_mask`. Opcode 30h consumes 4 words into the row lanes and opcode 31h consumes 4 words into the column lanes. The first word goes to lane 0, which is bits 31:0 of `cfg_row` or `cfg_col`.
- R7: Opcode 4Ah gives a one-cycle `mpg_req` with `mpg_addr`=imm×8 and `mpg_bytes`=count×8, where a count of 0 means 2048 bytes. The count×2 words that follow (512 when the count is 0) each appear on `pay_data` with `pay_valid`=1 and `pay_to_gif`=0, one cycle after the word is accepted.
- R8: Opcode 50h gives a one-cycle `gif_req` with `gif_qwords`=imm, where an immediate of 0 means 65536. The imm×4 words that follow each appear on `pay_data` with `pay_valid`=1 and `pay_to_gif`=1.
- R9: If bit 31 is set, `irq` rises one cycle after the command completes. A command with no payload completes when it is accepted; a command with payload completes when its last payload word is accepted. `irq` then stays high until a cycle with `irq_ack`=1.
- R10: While `irq` is high, a command word is refused (`in_ready`=0) unless its opcode is 07h. A MARK word is accepted and executed.
- R11: An opcode outside the set 00h, 01h–05h, 07h, 14h, 17h, 20h, 30h, 31h, 4Ah, 50h changes no configuration and consumes no payload. It sets `op_err`, which stays set until reset.
- R12: Payload words are never decoded as commands. A payload word that looks like a MARK command leaves `cfg_mark` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word (command or payload) |
| in_ready | output | 1 | Word accepted at this edge when valid |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request |
| vu_start | output | 1 | Vector unit start pulse |
| vu_use_tpc | output | 1 | Start resumes at the saved program counter |
| vu_addr | output | 19 | Start address in bytes |
| mpg_req | output | 1 | Micro-memory upload pulse |
| mpg_addr | output | 19 | Upload byte address |
| mpg_bytes | output | 12 | Upload length in bytes |
| gif_req | output | 1 | Graphics interface forward pulse |
| gif_qwords | output | 17 | Forward length in quadwords |
| pay_valid | output | 1 | Forwarded payload beat |
| pay_to_gif | output | 1 | Beat goes to the graphics interface (1) or to micro memory (0) |
| pay_data | output | 32 | Forwarded payload word |
| cfg_cl | output | 8 | Cycle length |
| cfg_wl | output | 8 | Write length |
| cfg_ofs | output | 10 | Double-buffer offset |
| cfg_base | output | 10 | Double-buffer base |
| cfg_itop | output | 10 | ITOP value |
| cfg_mode | output | 2 | Add mode |
| cfg_mark | output | 16 | Mark value |
| cfg_mask | output | 32 | Write mask |
| cfg_row | output | 128 | Row fill lanes, lane 0 in bits 31:0 |
| cfg_col | output | 128 | Column fill lanes, lane 0 in bits 31:0 |
| cfg_dbf | output | 1 | Double-buffer flag |
| tops | output | 10 | Current buffer start |
| op_err | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench sends a 512-word upload with a zero count and a forward with a zero immediate. A decoder that dropped the zero-count wrap would announce zero bytes or zero quadwords and decode the first payload word as a command. A payload word shaped like MARK is placed inside a burst: an off-by-one in the word counter would let it overwrite `cfg_mark`. The interrupt stall is tested in three ways. A refused NOP is held for several cycles, and a MARK is passed through while stalled. The flag is set on a payload command, where raising `irq` at the header instead of after the last word would be caught. Random sequences of offset and start commands exercise the `tops` arithmetic, which would go wrong if the base were loaded after the flag cleared.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam int WORD_W  = 32;
  localparam int OP_W    = 7;
  localparam int REG_W   = 10;
  localparam int CNT_W   = 19;
  localparam int BYTES_W = 12;
  localparam int QW_W    = 17;
  localparam int ADDR_W  = 19;

  localparam logic [OP_W-1:0] OP_NOP    = 7'h00;
  localparam logic [OP_W-1:0] OP_CYCLE  = 7'h01;
  localparam logic [OP_W-1:0] OP_OFST   = 7'h02;
  localparam logic [OP_W-1:0] OP_BASE   = 7'h03;
  localparam logic [OP_W-1:0] OP_ITOP   = 7'h04;
  localparam logic [OP_W-1:0] OP_MODE   = 7'h05;
  localparam logic [OP_W-1:0] OP_MARK   = 7'h07;
  localparam logic [OP_W-1:0] OP_START  = 7'h14;
  localparam logic [OP_W-1:0] OP_RESUME = 7'h17;
  localparam logic [OP_W-1:0] OP_MASK   = 7'h20;
  localparam logic [OP_W-1:0] OP_ROW    = 7'h30;
  localparam logic [OP_W-1:0] OP_COL    = 7'h31;
  localparam logic [OP_W-1:0] OP_UPLOAD = 7'h4A;
  localparam logic [OP_W-1:0] OP_FWD    = 7'h50;

  function automatic logic known_op(input logic [OP_W-1:0] op);
    case (op)
      OP_NOP, OP_CYCLE, OP_OFST, OP_BASE, OP_ITOP, OP_MODE, OP_MARK,
      OP_START, OP_RESUME, OP_MASK, OP_ROW, OP_COL, OP_UPLOAD, OP_FWD:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Upload length in bytes; a zero count wraps to the full 2 KiB.
  function automatic logic [BYTES_W-1:0] upload_bytes(input logic [7:0] num);
    return (num == 8'd0) ? 12'd2048 : {1'b0, num, 3'b000};
  endfunction

  // Forward length in quadwords; a zero immediate wraps to 65536.
  function automatic logic [QW_W-1:0] fwd_qwords(input logic [15:0] imm);
    return (imm == 16'd0) ? 17'h10000 : {1'b0, imm};
  endfunction

  // Number of payload words that follow a command header.
  function automatic logic [CNT_W-1:0] pay_words(input logic [OP_W-1:0] op,
                                                 input logic [7:0] num,
                                                 input logic [15:0] imm);
    case (op)
      OP_MASK:       return CNT_W'(1);
      OP_ROW, OP_COL: return CNT_W'(4);
      OP_UPLOAD:     return (num == 8'd0) ? CNT_W'(512) : {10'd0, num, 1'b0};
      OP_FWD:        return {fwd_qwords(imm), 2'b00};
      default:       return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] tops_of(input logic [REG_W-1:0] base,
                                               input logic [REG_W-1:0] ofs,
                                               input logic dbf);
    return dbf ? REG_W'(base + ofs) : base;
  endfunction
endpackage

// File: rtl/vcmd_stall.sv
module vcmd_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (ack_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/vcmd_burst.sv
module vcmd_burst #(
  parameter int CNT_W = 19,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             take_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_o  <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      idx_o  <= '0;
    end else if (take_i) begin
      left_q <= left_q - CNT_W'(1);
      idx_o  <= idx_o + IDX_W'(1);
    end
  end

  assign busy_o = (left_q != '0);
  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/vcmd_cfg.sv
module vcmd_cfg
  import vcmd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_go,
  input  logic [OP_W-1:0]         cmd_op,
  input  logic [15:0]             cmd_imm,
  input  logic                    word_go,
  input  logic [OP_W-1:0]         word_op,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [WORD_W-1:0]       word_data,
  input  logic                    start_go,
  output logic [7:0]              cl_o,
  output logic [7:0]              wl_o,
  output logic [REG_W-1:0]        ofs_o,
  output logic [REG_W-1:0]        base_o,
  output logic [REG_W-1:0]        itop_o,
  output logic [1:0]              mode_o,
  output logic [15:0]             mark_o,
  output logic [WORD_W-1:0]       mask_o,
  output logic [LANES*WORD_W-1:0] row_o,
  output logic [LANES*WORD_W-1:0] col_o,
  output logic                    dbf_o,
  output logic [REG_W-1:0]        tops_o
);
  logic [WORD_W-1:0] row_r [LANES];
  logic [WORD_W-1:0] col_r [LANES];

  assign tops_o = tops_of(base_o, ofs_o, dbf_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_o   <= '0;
      wl_o   <= '0;
      ofs_o  <= '0;
      base_o <= '0;
      itop_o <= '0;
      mode_o <= '0;
      mark_o <= '0;
      dbf_o  <= 1'b0;
    end else if (cmd_go) begin
      case (cmd_op)
        OP_CYCLE: begin
          cl_o <= cmd_imm[7:0];
          wl_o <= cmd_imm[15:8];
        end
        OP_OFST: begin
          ofs_o  <= cmd_imm[REG_W-1:0];
          base_o <= tops_o;
          dbf_o  <= 1'b0;
        end
        OP_BASE: base_o <= cmd_imm[REG_W-1:0];
        OP_ITOP: itop_o <= cmd_imm[REG_W-1:0];
        OP_MODE: mode_o <= cmd_imm[1:0];
        OP_MARK: mark_o <= cmd_imm;
        default: ;
      endcase
      if (start_go) dbf_o <= ~dbf_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      for (int i = 0; i < LANES; i++) begin
        row_r[i] <= '0;
        col_r[i] <= '0;
      end
    end else if (word_go) begin
      case (word_op)
        OP_MASK: mask_o          <= word_data;
        OP_ROW:  row_r[word_idx] <= word_data;
        OP_COL:  col_r[word_idx] <= word_data;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign row_o[g*WORD_W +: WORD_W] = row_r[g];
    assign col_o[g*WORD_W +: WORD_W] = col_r[g];
  end
endmodule

// File: rtl/vcmd_decoder.sv
module vcmd_decoder
  import vcmd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic                    irq_ack,
  output logic                    irq,
  output logic                    vu_start,
  output logic                    vu_use_tpc,
  output logic [ADDR_W-1:0]       vu_addr,
  output logic                    mpg_req,
  output logic [ADDR_W-1:0]       mpg_addr,
  output logic [BYTES_W-1:0]      mpg_bytes,
  output logic                    gif_req,
  output logic [QW_W-1:0]         gif_qwords,
  output logic                    pay_valid,
  output logic                    pay_to_gif,
  output logic [WORD_W-1:0]       pay_data,
  output logic [7:0]              cfg_cl,
  output logic [7:0]              cfg_wl,
  output logic [REG_W-1:0]        cfg_ofs,
  output logic [REG_W-1:0]        cfg_base,
  output logic [REG_W-1:0]        cfg_itop,
  output logic [1:0]              cfg_mode,
  output logic [15:0]             cfg_mark,
  output logic [WORD_W-1:0]       cfg_mask,
  output logic [LANES*WORD_W-1:0] cfg_row,
  output logic [LANES*WORD_W-1:0] cfg_col,
  output logic                    cfg_dbf,
  output logic [REG_W-1:0]        tops,
  output logic                    op_err
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Header fields
  logic [OP_W-1:0]  hdr_op;
  logic [7:0]       hdr_num;
  logic [15:0]      hdr_imm;
  logic             hdr_irq;
  logic [CNT_W-1:0] hdr_len;
  assign hdr_irq = in_data[31];
  assign hdr_op  = in_data[30:24];
  assign hdr_num = in_data[23:16];
  assign hdr_imm = in_data[15:0];
  assign hdr_len = pay_words(hdr_op, hdr_num, hdr_imm);

  // Named internal events
  logic busy, last;
  logic [IDX_W-1:0] idx;
  logic evt_cmd, evt_pay, evt_offset, evt_start, evt_done_irq;
  logic [OP_W-1:0] cur_op;
  logic cur_irq;

  assign in_ready     = busy || !(irq && hdr_op != OP_MARK);
  assign evt_cmd      = in_valid && in_ready && !busy;
  assign evt_pay      = in_valid && busy;
  assign evt_offset   = evt_cmd && (hdr_op == OP_OFST);
  assign evt_start    = evt_cmd && (hdr_op == OP_START || hdr_op == OP_RESUME);
  assign evt_done_irq = (evt_cmd && hdr_irq && hdr_len == '0)
                      || (evt_pay && last && cur_irq);

  vcmd_burst #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .load_i(evt_cmd && hdr_len != '0), .len_i(hdr_len),
    .take_i(evt_pay), .busy_o(busy), .last_o(last), .idx_o(idx)
  );

  vcmd_stall u_stall (
    .clk(clk), .rst_n(rst_n),
    .set_i(evt_done_irq), .ack_i(irq_ack), .irq_o(irq)
  );

  vcmd_cfg #(.LANES(LANES), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(evt_cmd), .cmd_op(hdr_op), .cmd_imm(hdr_imm),
    .word_go(evt_pay), .word_op(cur_op), .word_idx(idx), .word_data(in_data),
    .start_go(evt_start),
    .cl_o(cfg_cl), .wl_o(cfg_wl), .ofs_o(cfg_ofs), .base_o(cfg_base),
    .itop_o(cfg_itop), .mode_o(cfg_mode), .mark_o(cfg_mark), .mask_o(cfg_mask),
    .row_o(cfg_row), .col_o(cfg_col), .dbf_o(cfg_dbf), .tops_o(tops)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op  <= OP_NOP;
      cur_irq <= 1'b0;
      op_err  <= 1'b0;
    end else if (evt_cmd) begin
      cur_op  <= hdr_op;
      cur_irq <= hdr_irq;
      if (!known_op(hdr_op)) op_err <= 1'b1;
    end
  end

  // Downstream request pulses and payload beats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vu_start   <= 1'b0;
      vu_use_tpc <= 1'b0;
      vu_addr    <= '0;
      mpg_req    <= 1'b0;
      mpg_addr   <= '0;
      mpg_bytes  <= '0;
      gif_req    <= 1'b0;
      gif_qwords <= '0;
      pay_valid  <= 1'b0;
      pay_to_gif <= 1'b0;
      pay_data   <= '0;
    end else begin
      vu_start  <= evt_start;
      mpg_req   <= evt_cmd && (hdr_op == OP_UPLOAD);
      gif_req   <= evt_cmd && (hdr_op == OP_FWD);
      pay_valid <= evt_pay && (cur_op == OP_UPLOAD || cur_op == OP_FWD);
      if (evt_start) begin
        vu_use_tpc <= (hdr_op == OP_RESUME);
        vu_addr    <= {hdr_imm, 3'b000};
      end
      if (evt_cmd && hdr_op == OP_UPLOAD) begin
        mpg_addr  <= {hdr_imm, 3'b000};
        mpg_bytes <= upload_bytes(hdr_num);
      end
      if (evt_cmd && hdr_op == OP_FWD) gif_qwords <= fwd_qwords(hdr_imm);
      if (evt_pay) begin
        pay_data   <= in_data;
        pay_to_gif <= (cur_op == OP_FWD);
      end
    end
  end
endmodule

// File: rtl/vcmd_decoder_chk.sv
module vcmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] in_op,
  input logic       evt_cmd,
  input logic       evt_pay,
  input logic       evt_offset,
  input logic       irq,
  input logic       irq_ack,
  input logic       op_err,
  input logic       cfg_dbf,
  input logic       vu_start,
  input logic       mpg_req,
  input logic       gif_req,
  input logic       pay_valid
);
  AST_STALL_ONLY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmd && irq) |-> (in_op == 7'h07)); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> op_err); // R11
  AST_OFFSET_CLEARS_DBF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_offset |=> !cfg_dbf); // R3
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vu_start, mpg_req, gif_req})); // R5
  AST_REQ_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (vu_start || mpg_req || gif_req) |-> $past(evt_cmd)); // R5
  AST_BEAT_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(evt_pay)); // R12
  AST_START_FLIPS_DBF: assert property (@(posedge clk) disable iff (!rst_n)
    vu_start |-> (cfg_dbf != $past(cfg_dbf))); // R5
endmodule

bind vcmd_decoder vcmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_op(hdr_op), .evt_cmd(evt_cmd),
  .evt_pay(evt_pay), .evt_offset(evt_offset), .irq(irq), .irq_ack(irq_ack),
  .op_err(op_err), .cfg_dbf(cfg_dbf), .vu_start(vu_start),
  .mpg_req(mpg_req), .gif_req(gif_req), .pay_valid(pay_valid)
);

// File: tb/vcmd_decoder_test.sv
`timescale 1ns/1ps
module vcmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic irq_ack = 1'b0;
  logic in_ready, irq, vu_start, vu_use_tpc, mpg_req, gif_req;
  logic pay_valid, pay_to_gif, cfg_dbf, op_err;
  logic [18:0] vu_addr, mpg_addr;
  logic [11:0] mpg_bytes;
  logic [16:0] gif_qwords;
  logic [31:0] pay_data, cfg_mask;
  logic [7:0] cfg_cl, cfg_wl;
  logic [9:0] cfg_ofs, cfg_base, cfg_itop, tops;
  logic [1:0] cfg_mode;
  logic [15:0] cfg_mark;
  logic [127:0] cfg_row, cfg_col;

  int checks = 0;
  int errs = 0;

  // Bench model
  logic [7:0] e_cl, e_wl;
  logic [9:0] e_ofs, e_base, e_itop;
  logic [1:0] e_mode;
  logic [15:0] e_mark;
  logic [31:0] e_mask;
  logic [31:0] e_row [4];
  logic [31:0] e_col [4];
  logic e_dbf, e_err;

  always #2.5 clk = ~clk;

  vcmd_decoder uut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] m_tops();
    return e_dbf ? 10'(e_base + e_ofs) : e_base;
  endfunction

  task automatic check_cfg();
    chk("R2 cl", cfg_cl, e_cl);
    chk("R2 wl", cfg_wl, e_wl);
    chk("R3 ofs", cfg_ofs, e_ofs);
    chk("R2 R3 base", cfg_base, e_base);
    chk("R2 itop", cfg_itop, e_itop);
    chk("R2 mode", cfg_mode, e_mode);
    chk("R2 mark", cfg_mark, e_mark);
    chk("R6 mask", cfg_mask, e_mask);
    chk("R6 row", cfg_row, {e_row[3], e_row[2], e_row[1], e_row[0]});
    chk("R6 col", cfg_col, {e_col[3], e_col[2], e_col[1], e_col[0]});
    chk("R3 R5 dbf", cfg_dbf, e_dbf);
    chk("R4 tops", tops, m_tops());
    chk("R11 err", op_err, e_err);
  endtask

  // Starts and ends at a falling edge; registered results are visible on return.
  task automatic send(input logic [31:0] w);
    in_data = w;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic model_cmd(input logic [6:0] op, input logic [15:0] imm);
    case (op)
      7'h01: begin e_cl = imm[7:0]; e_wl = imm[15:8]; end
      7'h02: begin e_base = m_tops(); e_ofs = imm[9:0]; e_dbf = 1'b0; end
      7'h03: e_base = imm[9:0];
      7'h04: e_itop = imm[9:0];
      7'h05: e_mode = imm[1:0];
      7'h07: e_mark = imm;
      7'h14, 7'h17: e_dbf = ~e_dbf;
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [6:0] ops [12] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05,
                            7'h07, 7'h14, 7'h17, 7'h20, 7'h30, 7'h31};
    logic [31:0] w;
    e_cl = '0; e_wl = '0; e_ofs = '0; e_base = '0; e_itop = '0; e_mode = '0;
    e_mark = '0; e_mask = '0; e_dbf = 1'b0; e_err = 1'b0;
    for (int i = 0; i < 4; i++) begin e_row[i] = '0; e_col[i] = '0; end
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_cfg();
    chk("R1 ready", in_ready, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pulses", {vu_start, mpg_req, gif_req, pay_valid}, 4'b0);

    // Random configuration, start and load commands (R2..R6)
    for (int n = 0; n < 400; n++) begin
      logic [6:0] op;
      logic [15:0] imm;
      op = ops[$urandom % 12];
      imm = 16'($urandom);
      send({1'b0, op, 8'($urandom), imm});
      model_cmd(op, imm);
      if (op == 7'h14 || op == 7'h17) begin
        chk("R5 start", vu_start, 1'b1);
        chk("R5 tpc", vu_use_tpc, op == 7'h17);
        if (op == 7'h14) chk("R5 addr", vu_addr, {imm, 3'b000});
      end else begin
        chk("R5 no start", vu_start, 1'b0);
      end
      if (op == 7'h20) begin
        w = $urandom;
        send(w);
        e_mask = w;
      end else if (op == 7'h30 || op == 7'h31) begin
        for (int k = 0; k < 4; k++) begin
          w = $urandom;
          send(w);
          if (op == 7'h30) e_row[k] = w; else e_col[k] = w;
        end
      end
      check_cfg();
    end

    // Bit 31 does not alter the opcode; irq after a command without payload (R2, R9)
    send(32'h8100_0203);
    model_cmd(7'h01, 16'h0203);
    check_cfg();
    chk("R9 irq rises", irq, 1'b1);
    // Stall on a NOP (R10)
    in_data = 32'h0000_0000;
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 stalled", in_ready, 1'b0);
      @(negedge clk);
    end
    chk("R9 irq held", irq, 1'b1);
    // MARK passes while stalled (R10)
    in_data = 32'h0700_abcd;
    #1;
    chk("R10 mark ready", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    e_mark = 16'habcd;
    chk("R10 mark done", cfg_mark, e_mark);
    chk("R9 irq after mark", irq, 1'b1);
    // Acknowledge releases (R9)
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 irq cleared", irq, 1'b0);
    send(32'h0000_0000);
    check_cfg();

    // irq on a payload command waits for the last word (R9)
    send(32'hA000_0000);
    chk("R9 no irq at header", irq, 1'b0);
    send(32'h1357_9bdf);
    e_mask = 32'h1357_9bdf;
    chk("R9 irq after payload", irq, 1'b1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check_cfg();

    // Unknown opcode (R11)
    send(32'h6000_1111);
    e_err = 1'b1;
    check_cfg();
    send(32'h0700_2222);
    e_mark = 16'h2222;
    check_cfg();

    // Upload with count 3 (R7, R12)
    send(32'h4A03_0010);
    chk("R7 req", mpg_req, 1'b1);
    chk("R7 addr", mpg_addr, 19'h80);
    chk("R7 bytes", mpg_bytes, 12'd24);
    for (int k = 0; k < 6; k++) begin
      w = (k == 2) ? 32'h0700_5555 : $urandom;
      send(w);
      chk("R7 beat", {pay_valid, pay_to_gif}, 2'b10);
      chk("R7 data", pay_data, w);
    end
    @(negedge clk);
    chk("R7 beats end", pay_valid, 1'b0);
    check_cfg();

    // Upload with zero count wraps to 2048 bytes / 512 words (R7)
    send(32'h4A00_0001);
    chk("R7 zero bytes", mpg_bytes, 12'd2048);
    for (int k = 0; k < 512; k++) begin
      w = $urandom;
      send(w);
      chk("R7 zero beat", {pay_valid, pay_to_gif, pay_data}, {2'b10, w});
    end
    send(32'h0700_3333);
    e_mark = 16'h3333;
    chk("R7 R12 next cmd", cfg_mark, e_mark);

    // Forward 2 quadwords (R8)
    send(32'h5000_0002);
    chk("R8 req", gif_req, 1'b1);
    chk("R8 qwords", gif_qwords, 17'd2);
    for (int k = 0; k < 8; k++) begin
      w = $urandom;
      send(w);
      chk("R8 beat", {pay_valid, pay_to_gif, pay_data}, {2'b11, w});
    end
    check_cfg();

    // Forward with zero immediate wraps to 65536 (R8, R12)
    send(32'h5000_0000);
    chk("R8 zero qwords", gif_qwords, 17'h10000);
    send(32'h0700_9999);
    chk("R12 word forwarded", {pay_valid, pay_to_gif}, 2'b11);
    chk("R12 mark unchanged", cfg_mark, e_mark);

    finish_run();
  end
endmodule